// File: doc/BRIEF.md
# Multithreaded Instruction Fetch Selector

This block sits ahead of a superscalar instruction fetch path and owns one program counter register per hardware thread. Every cycle it decides which thread, or which pair of threads, supplies the fetch group. It presents the group's fetch address or addresses, the thread that owns each slot, and a valid bit for each slot. Every thread keeps its state in its own register, so changing threads costs no cycles.

A two-bit mode input selects the policy. Fine-grain interleave hands the whole group to a different ready thread on every cycle. Coarse-grain runs keep one thread for a programmable number of fetches before rotating. Split fetch divides the group into two halves, each fetched from a different thread. Threads that are not ready are skipped in round-robin order. A per-thread redirect loads a new target into that thread's counter only. Otherwise a thread's counter advances by the bytes it fetched.

Top module: `mtf_fetch_sel`

## Requirements
- R1: After reset, thread t's PC is BOOT_PC + t*THREAD_STRIDE, and the first fetch with all threads ready goes to thread 0.
- R2: In fine-grain mode (mode 2'b01, and also the unused code 2'b11), each fetch goes to the first ready thread after the previous owner in round-robin order. With more than one thread ready, the thread therefore changes on every cycle.
- R3: In coarse-grain mode (mode 2'b00), the owner keeps fetching while it is ready, up to RUN_LEN consecutive fetches. After that run, or as soon as the owner is not ready, fetch passes to the next ready thread in round-robin order and a new run starts.
- R4: In split mode (mode 2'b10), slots 0..FETCH_W/2-1 belong to thread A, the first ready thread after the owner. The upper slots belong to thread B, the next ready thread after A. B becomes the owner.
- R5: In split mode with exactly one thread ready, only the lower half of the slots is valid.
- R6: With no thread ready, every slot_valid bit is 0, and no PC or selection state changes.
- R7: Each valid slot's field in slot_tid (TID_W bits at position slot*TID_W) holds the thread that owns it, and that thread is ready. Invalid slots carry 0.
- R8: A fetched thread's PC advances by its slot count times INSN_BYTES. In full-width modes, fetch_pc_b equals fetch_pc_a + (FETCH_W/2)*INSN_BYTES.
- R9: A redirect replaces only its own thread's PC, overrides that thread's advance in the same cycle, and is the address of that thread's next fetch.
- R10: Whenever at least one thread is ready, slot 0 is valid, including in cycles that change thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 coarse, 01 fine, 10 split, 11 fine |
| thr_ready | input | NUM_THREADS | Per-thread ready-to-fetch flag |
| redir_valid | input | NUM_THREADS | Per-thread redirect strobe |
| redir_pc | input | NUM_THREADS*PC_W | Per-thread redirect target, thread t at bits t*PC_W |
| fetch_pc_a | output | PC_W | Address of the group, or of the lower half in split mode |
| fetch_pc_b | output | PC_W | Address of the upper half |
| slot_valid | output | FETCH_W | Per-slot valid |
| slot_tid | output | FETCH_W*TID_W | Per-slot thread ID |

## Verification
The bench builds the block with four threads, a four-slot group, 32-bit PCs and RUN_LEN of 3. A run length of 3 makes a coarse run end, and restart on a lone ready thread, within a short stimulus table. Four threads make it possible to apply ready masks that skip over the owner, that leave one thread, or that leave none. In split mode these show the B picker wrapping past the highest index and the upper half dropping out.

// File: rtl/mtf_pkg.sv
package mtf_pkg;

  typedef enum logic [1:0] {
    FM_COARSE = 2'b00,
    FM_FINE   = 2'b01,
    FM_SPLIT  = 2'b10,
    FM_ALT    = 2'b11
  } fetch_mode_e;

  // position k steps after start in a ring of n entries
  function automatic int unsigned rr_index(int unsigned start, int unsigned k,
                                           int unsigned n);
    return (start + k) % n;
  endfunction

  // bytes covered by a fetch of the given slot count
  function automatic int unsigned group_bytes(int unsigned slots,
                                              int unsigned insn_bytes);
    return slots * insn_bytes;
  endfunction

  // reset address of one thread
  function automatic int unsigned thread_boot(int unsigned base, int unsigned stride,
                                              int unsigned tid);
    return base + tid * stride;
  endfunction

endpackage

// File: rtl/mtf_rr_pick.sv
module mtf_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  import mtf_pkg::*;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    // scan from the far end so the nearest requester wins
    for (int k = N - 1; k >= 0; k--) begin
      logic [IW-1:0] j;
      j = IW'(rr_index(32'(start), k, N));
      if (req[j]) begin
        found = 1'b1;
        idx   = j;
      end
    end
  end

endmodule

// File: rtl/mtf_pc_file.sv
module mtf_pc_file #(
  parameter int          N             = 4,
  parameter int          PC_W          = 32,
  parameter int          FETCH_W       = 4,
  parameter int          INSN_BYTES    = 4,
  parameter int unsigned BOOT_PC       = 0,
  parameter int unsigned THREAD_STRIDE = 32'h1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            adv_full,
  input  logic [N-1:0]            adv_half,
  input  logic [N-1:0]            redir_valid,
  input  logic [N*PC_W-1:0]       redir_pc,
  output logic [N-1:0][PC_W-1:0]  pc
);
  import mtf_pkg::*;

  localparam logic [PC_W-1:0] STEP_FULL = PC_W'(group_bytes(FETCH_W, INSN_BYTES));
  localparam logic [PC_W-1:0] STEP_HALF = PC_W'(group_bytes(FETCH_W / 2, INSN_BYTES));

  for (genvar t = 0; t < N; t++) begin : g_thr
    localparam logic [PC_W-1:0] RST_PC = PC_W'(thread_boot(BOOT_PC, THREAD_STRIDE, t));
    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q <= RST_PC;
      end else if (redir_valid[t]) begin
        pc_q <= redir_pc[t*PC_W +: PC_W];
      end else if (adv_full[t]) begin
        pc_q <= pc_q + STEP_FULL;
      end else if (adv_half[t]) begin
        pc_q <= pc_q + STEP_HALF;
      end
    end

    assign pc[t] = pc_q;
  end

endmodule

// File: rtl/mtf_sched.sv
module mtf_sched #(
  parameter int N       = 4,
  parameter int RUN_LEN = 4,
  parameter int IW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [N-1:0]  ready,
  output logic          sel_valid,
  output logic [IW-1:0] sel_a,
  output logic          pair_valid,
  output logic [IW-1:0] sel_b,
  output logic          ev_stay,
  output logic          ev_pair
);
  import mtf_pkg::*;

  localparam int              CNT_W   = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic [IW-1:0]    owner_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_coarse, is_split, stay;
  logic [IW-1:0]    start_a, start_b, a_idx, b_idx;
  logic             a_hit, b_hit;
  logic [N-1:0]     req_b;

  assign is_coarse = (mode == FM_COARSE);
  assign is_split  = (mode == FM_SPLIT);

  assign start_a = IW'(rr_index(32'(owner_q), 1, N));

  mtf_rr_pick #(.N(N), .IW(IW)) u_pick_a (
    .req(ready), .start(start_a), .found(a_hit), .idx(a_idx)
  );

  assign stay      = is_coarse && ready[owner_q] && (cnt_q < RUN_MAX);
  assign sel_valid = stay || a_hit;
  assign sel_a     = stay ? owner_q : a_idx;

  assign req_b   = ready & ~(N'(1) << sel_a);
  assign start_b = IW'(rr_index(32'(sel_a), 1, N));

  mtf_rr_pick #(.N(N), .IW(IW)) u_pick_b (
    .req(req_b), .start(start_b), .found(b_hit), .idx(b_idx)
  );

  assign pair_valid = is_split && sel_valid && b_hit;
  assign sel_b      = b_idx;
  assign ev_stay    = stay;
  assign ev_pair    = pair_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= IW'(N - 1);
      cnt_q   <= RUN_MAX;
    end else if (sel_valid) begin
      owner_q <= pair_valid ? b_idx : sel_a;
      cnt_q   <= stay ? cnt_q + 1'b1 : CNT_W'(1);
    end
  end

endmodule

// File: rtl/mtf_fetch_sel.sv
module mtf_fetch_sel #(
  parameter int          NUM_THREADS   = 4,
  parameter int          FETCH_W       = 4,
  parameter int          PC_W          = 32,
  parameter int          RUN_LEN       = 4,
  parameter int          INSN_BYTES    = 4,
  parameter int unsigned BOOT_PC       = 0,
  parameter int unsigned THREAD_STRIDE = 32'h1000,
  localparam int         TID_W         = $clog2(NUM_THREADS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  mode,
  input  logic [NUM_THREADS-1:0]      thr_ready,
  input  logic [NUM_THREADS-1:0]      redir_valid,
  input  logic [NUM_THREADS*PC_W-1:0] redir_pc,
  output logic [PC_W-1:0]             fetch_pc_a,
  output logic [PC_W-1:0]             fetch_pc_b,
  output logic [FETCH_W-1:0]          slot_valid,
  output logic [FETCH_W*TID_W-1:0]    slot_tid
);
  import mtf_pkg::*;

  localparam int              HALF       = FETCH_W / 2;
  localparam logic [PC_W-1:0] HALF_BYTES = PC_W'(group_bytes(HALF, INSN_BYTES));

  logic                               sel_valid, pair_valid, ev_stay, ev_pair;
  logic [TID_W-1:0]                   sel_a, sel_b;
  logic                               is_split;
  logic [NUM_THREADS-1:0]             adv_full, adv_half;
  logic [NUM_THREADS-1:0][PC_W-1:0]   pc;

  assign is_split = (mode == FM_SPLIT);

  mtf_sched #(.N(NUM_THREADS), .RUN_LEN(RUN_LEN), .IW(TID_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ready(thr_ready),
    .sel_valid(sel_valid), .sel_a(sel_a), .pair_valid(pair_valid), .sel_b(sel_b),
    .ev_stay(ev_stay), .ev_pair(ev_pair)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_adv
    assign adv_full[t] = sel_valid && !is_split && (sel_a == TID_W'(t));
    assign adv_half[t] = is_split && ((sel_valid && (sel_a == TID_W'(t))) ||
                                      (pair_valid && (sel_b == TID_W'(t))));
  end

  mtf_pc_file #(
    .N(NUM_THREADS), .PC_W(PC_W), .FETCH_W(FETCH_W), .INSN_BYTES(INSN_BYTES),
    .BOOT_PC(BOOT_PC), .THREAD_STRIDE(THREAD_STRIDE)
  ) u_pcs (
    .clk(clk), .rst_n(rst_n), .adv_full(adv_full), .adv_half(adv_half),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .pc(pc)
  );

  assign fetch_pc_a = pc[sel_a];
  assign fetch_pc_b = pair_valid ? pc[sel_b] : pc[sel_a] + HALF_BYTES;

  for (genvar s = 0; s < FETCH_W; s++) begin : g_slot
    if (s < HALF) begin : g_lo
      assign slot_valid[s]                = sel_valid;
      assign slot_tid[s*TID_W +: TID_W]   = sel_valid ? sel_a : '0;
    end else begin : g_hi
      logic hv;
      assign hv                           = is_split ? pair_valid : sel_valid;
      assign slot_valid[s]                = hv;
      assign slot_tid[s*TID_W +: TID_W]   = !hv ? '0 : (is_split ? sel_b : sel_a);
    end
  end

endmodule

// File: rtl/mtf_fetch_sel_chk.sv
module mtf_fetch_sel_chk #(
  parameter int NUM_THREADS = 4,
  parameter int FETCH_W     = 4,
  parameter int PC_W        = 32,
  parameter int RUN_LEN     = 4,
  parameter int TID_W       = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [1:0]                  mode,
  input logic [NUM_THREADS-1:0]      thr_ready,
  input logic [NUM_THREADS-1:0]      redir_valid,
  input logic [NUM_THREADS*PC_W-1:0] redir_pc,
  input logic [PC_W-1:0]             fetch_pc_a,
  input logic [FETCH_W-1:0]          slot_valid,
  input logic [FETCH_W*TID_W-1:0]    slot_tid,
  input logic                        ev_stay
);
  localparam int HALF = FETCH_W / 2;
  localparam int RW   = $clog2(RUN_LEN + 1) + 1;

  logic [TID_W-1:0] tid_lo, tid_hi, last_tid, top_tid;
  logic             have_last, last_coarse, is_coarse, is_split, is_fine;
  logic [RW-1:0]    run_q;

  assign tid_lo    = slot_tid[0 +: TID_W];
  assign tid_hi    = slot_tid[HALF*TID_W +: TID_W];
  assign top_tid   = slot_valid[FETCH_W-1] ? tid_hi : tid_lo;
  assign is_coarse = (mode == 2'b00);
  assign is_split  = (mode == 2'b10);
  assign is_fine   = !is_coarse && !is_split;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_tid    <= '0;
      have_last   <= 1'b0;
      last_coarse <= 1'b0;
      run_q       <= '0;
    end else if (slot_valid[0]) begin
      have_last   <= 1'b1;
      last_tid    <= top_tid;
      last_coarse <= is_coarse;
      if (have_last && is_coarse && last_coarse && tid_lo == last_tid)
        run_q <= (run_q == RW'(RUN_LEN)) ? RW'(1) : run_q + 1'b1;
      else
        run_q <= RW'(1);
    end
  end

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ready == '0) |-> (slot_valid == '0));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ready != '0) |-> slot_valid[0]);

  p_owner_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[0] |-> (thr_ready[tid_lo] &&
                       (!slot_valid[FETCH_W-1] || thr_ready[tid_hi])));

  p_fine_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fine && slot_valid[0] && have_last && $countones(thr_ready) > 1)
      |-> (tid_lo != last_tid));

  p_split_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_split && slot_valid[FETCH_W-1]) |-> (tid_lo != tid_hi));

  p_run_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_coarse && last_coarse && slot_valid[0] && have_last &&
     run_q == RW'(RUN_LEN) && $countones(thr_ready) > 1) |-> (tid_lo != last_tid));

  p_stay_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stay && have_last) |-> (slot_valid[0] && tid_lo == last_tid));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_redir
    p_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid[t] |=> (!(slot_valid[0] && tid_lo == TID_W'(t)) ||
                          fetch_pc_a == $past(redir_pc[t*PC_W +: PC_W])));
  end

endmodule

bind mtf_fetch_sel mtf_fetch_sel_chk #(
  .NUM_THREADS(NUM_THREADS), .FETCH_W(FETCH_W), .PC_W(PC_W),
  .RUN_LEN(RUN_LEN), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .thr_ready(thr_ready),
  .redir_valid(redir_valid), .redir_pc(redir_pc), .fetch_pc_a(fetch_pc_a),
  .slot_valid(slot_valid), .slot_tid(slot_tid), .ev_stay(ev_stay)
);

// File: tb/mtf_fetch_sel_test.sv
module mtf_fetch_sel_test;

  localparam int NT = 4;
  localparam int W  = 4;
  localparam int PW = 32;
  localparam int TW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'b01;
  logic [NT-1:0]   thr_ready = '0;
  logic [NT-1:0]   redir_valid = '0;
  logic [NT*PW-1:0] redir_pc = '0;
  logic [PW-1:0]   fetch_pc_a, fetch_pc_b;
  logic [W-1:0]    slot_valid;
  logic [W*TW-1:0] slot_tid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [PW-1:0] exp_pc [NT];

  always #10 clk = ~clk;

  mtf_fetch_sel #(.NUM_THREADS(NT), .FETCH_W(W), .PC_W(PW), .RUN_LEN(3)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .thr_ready(thr_ready),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .fetch_pc_a(fetch_pc_a),
    .fetch_pc_b(fetch_pc_b), .slot_valid(slot_valid), .slot_tid(slot_tid)
  );

  // {mode, ready, valid mask, tid lower half, tid upper half, pad}
  localparam int NV = 21;
  localparam logic [15:0] VEC [NV] = '{
    {2'd1, 4'b1111, 4'hF, 2'd0, 2'd0, 2'd0},  // R1 first pick
    {2'd1, 4'b1111, 4'hF, 2'd1, 2'd1, 2'd0},
    {2'd1, 4'b1111, 4'hF, 2'd2, 2'd2, 2'd0},
    {2'd1, 4'b1011, 4'hF, 2'd3, 2'd3, 2'd0},
    {2'd1, 4'b0101, 4'hF, 2'd0, 2'd0, 2'd0},
    {2'd1, 4'b0000, 4'h0, 2'd0, 2'd0, 2'd0},
    {2'd1, 4'b0101, 4'hF, 2'd2, 2'd2, 2'd0},
    {2'd0, 4'b1111, 4'hF, 2'd2, 2'd2, 2'd0},  // coarse run
    {2'd0, 4'b1111, 4'hF, 2'd2, 2'd2, 2'd0},
    {2'd0, 4'b1111, 4'hF, 2'd3, 2'd3, 2'd0},
    {2'd0, 4'b1111, 4'hF, 2'd3, 2'd3, 2'd0},
    {2'd0, 4'b0111, 4'hF, 2'd0, 2'd0, 2'd0},
    {2'd0, 4'b0001, 4'hF, 2'd0, 2'd0, 2'd0},
    {2'd0, 4'b0001, 4'hF, 2'd0, 2'd0, 2'd0},
    {2'd0, 4'b0001, 4'hF, 2'd0, 2'd0, 2'd0},
    {2'd2, 4'b1111, 4'hF, 2'd1, 2'd2, 2'd0},  // split
    {2'd2, 4'b1111, 4'hF, 2'd3, 2'd0, 2'd0},
    {2'd2, 4'b0100, 4'h3, 2'd2, 2'd0, 2'd0},
    {2'd2, 4'b1001, 4'hF, 2'd3, 2'd0, 2'd0},
    {2'd2, 4'b0000, 4'h0, 2'd0, 2'd0, 2'd0},
    {2'd1, 4'b1111, 4'hF, 2'd1, 2'd1, 2'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // full-width fetch of one thread: check both addresses, then advance by 16
  task automatic full_fetch(input string req, input int t);
    chk(req, 64'(fetch_pc_a), 64'(exp_pc[t]));
    chk({req, " R8 pc_b"}, 64'(fetch_pc_b), 64'(exp_pc[t] + 32'd8));
    exp_pc[t] = exp_pc[t] + 32'd16;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) exp_pc[t] = PW'(t * 32'h1000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R6 idle after reset", 64'(slot_valid), 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      logic [3:0] rdy, vm;
      logic [1:0] lo, hi;
      string tag;
      {m, rdy, vm, lo, hi} = VEC[i][15:2];
      @(negedge clk);
      mode = m;
      thr_ready = rdy;
      #2;
      tag = (vm == 4'h0) ? "R6" : (m == 2'd0) ? "R3" : (m == 2'd2) ?
            ((vm == 4'h3) ? "R5" : "R4") : "R2";
      chk({tag, " valid"}, 64'(slot_valid), 64'(vm));
      chk("R7 slot tid", 64'(slot_tid), 64'({hi, hi, lo, lo}));
      if (rdy != 4'h0) chk("R10 no bubble", 64'(slot_valid[0]), 64'h1);
      if (i == 0) chk("R1 boot pc", 64'(fetch_pc_a), 64'h0);
      if (vm != 4'h0) begin
        if (m == 2'd2) begin
          chk("R8 split pc_a", 64'(fetch_pc_a), 64'(exp_pc[lo]));
          exp_pc[lo] = exp_pc[lo] + 32'd8;
          if (vm[3]) begin
            chk("R8 split pc_b", 64'(fetch_pc_b), 64'(exp_pc[hi]));
            exp_pc[hi] = exp_pc[hi] + 32'd8;
          end
        end else begin
          full_fetch("R8 pc_a", int'(lo));
        end
      end
    end

    // R9: redirect to a thread not being fetched
    @(negedge clk);
    mode = 2'b01;
    thr_ready = 4'b0001;
    redir_valid = 4'b0100;
    redir_pc[2*PW +: PW] = 32'h8000;
    #2;
    chk("R9 current fetch unaffected", 64'(slot_tid[1:0]), 64'h0);
    full_fetch("R9 current pc", 0);
    exp_pc[2] = 32'h8000;
    @(negedge clk);
    redir_valid = '0;
    thr_ready = 4'b0100;
    #2;
    chk("R9 redirected tid", 64'(slot_tid[1:0]), 64'h2);
    full_fetch("R9 redirect target", 2);
    @(negedge clk);
    thr_ready = 4'b0001;
    #2;
    full_fetch("R9 other thread kept", 0);

    // R9: redirect wins over the advance of the thread being fetched
    @(negedge clk);
    redir_valid = 4'b0001;
    redir_pc[0 +: PW] = 32'h4000;
    #2;
    full_fetch("R9 pre-redirect pc", 0);
    exp_pc[0] = 32'h4000;
    @(negedge clk);
    redir_valid = '0;
    #2;
    full_fetch("R9 redirect over advance", 0);

    // R2: unused mode code behaves as fine-grain
    @(negedge clk);
    mode = 2'b11;
    thr_ready = 4'b1111;
    #2;
    chk("R2 alt code first", 64'(slot_tid[1:0]), 64'h1);
    full_fetch("R2 alt pc", 1);
    @(negedge clk);
    #2;
    chk("R2 alt code rotates", 64'(slot_tid[1:0]), 64'h2);
    full_fetch("R2 alt pc", 2);

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule